// File: doc/BRIEF.md
# Accumulator Carry and Test-Flag Unit

This block sits next to a 32-bit accumulator datapath and owns two status flags: the carry flag C and the test/control flag TC. Each cycle in which the operation strobe is high, it takes an operation code, the current accumulator, a memory operand and a bit index. It computes the arithmetic result where the operation has one, and it registers the new values of C and TC.

Subtraction uses an inverted-borrow convention. C ends up 1 when no borrow occurs and 0 when one does. The subtract-with-borrow form feeds the complement of C back in as an extra unit to subtract. Addition sets C on carry out. A bit test copies one operand bit into TC. A normalize test sets TC when the accumulator is zero; otherwise it sets TC when the two top bits of the accumulator differ. Dedicated operations force either flag to 1 or 0.

The registered C output feeds conditional branch, call and return logic directly. Results appear one clock after the strobe, together with a done pulse.

Top module: `acc_flag_unit`

## Requirements
- R1: Op code 0 (subtract) yields acc − opnd modulo 2^32 and sets C to 1 when acc ≥ opnd unsigned, else 0.
- R2: Op code 1 (subtract with borrow) yields acc − opnd − (1 − C) modulo 2^32, and sets C to 1 exactly when acc ≥ opnd + (1 − C), compared as unsigned 33-bit values.
- R3: Op code 2 (add) yields acc + opnd modulo 2^32 and sets C to the carry out of bit 31.
- R4: Op code 3 (bit test) loads TC with opnd[bit_idx], where bit_idx is 5 bits wide and selects bits 0 to 31.
- R5: Op code 4 (normalize test) loads TC with 1 when acc is zero, and otherwise with acc[31] XOR acc[30].
- R6: Op codes 5 and 6 force C to 1 and 0; op codes 7 and 8 force TC to 1 and 0.
- R7: An operation leaves unchanged every flag it does not name. Ops 0–2 and 5–6 do not touch TC, and ops 3, 4, 7 and 8 do not touch C. Codes 9–15 change no flag. Every op other than 0–2 returns acc unchanged as its result.
- R8: With the strobe low, C, TC and the result hold their values, and done stays low.
- R9: A synchronous active-high reset clears C, TC, the result and done.
- R10: Result, flags and done update on the first rising edge at which the strobe is high, and done is high for exactly the cycles that follow a strobed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| acc_i | input | 32 | Current accumulator |
| opnd_i | input | 32 | Memory operand |
| bit_idx_i | input | 5 | Bit index for the bit test |
| res_o | output | 32 | Registered result |
| c_o | output | 1 | Carry flag, also the branch/call/return condition |
| tc_o | output | 1 | Test/control flag |
| done_o | output | 1 | Result valid, one cycle after the strobe |

## Verification
On every cycle, the embedded assertions check the following: flags and result hold while the strobe is low, reset clears the flags, the forced set and clear operations land, a bit test copies the chosen operand bit into TC, a zero accumulator under normalize gives TC=1, and done follows the strobe. The exact carry and borrow values need the bench's reference arithmetic over many operands. So do the borrow chain through C in subtract-with-borrow, and the corner operands 0, 0x7FFFFFFF, 0x80000000 and equal operands. The bench's scenarios also show which flag an operation leaves untouched across long mixed sequences.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SUB   = 4'd0,
    OP_SBB   = 4'd1,
    OP_ADD   = 4'd2,
    OP_TBIT  = 4'd3,
    OP_NORM  = 4'd4,
    OP_SETC  = 4'd5,
    OP_CLRC  = 4'd6,
    OP_SETTC = 4'd7,
    OP_CLRTC = 4'd8
  } op_e;

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_ADD);
  endfunction
endpackage

// File: rtl/acc_flag_arith.sv
module acc_flag_arith
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_next,
  output logic              c_we
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] a_ext, b_ext, subtr, wide;

  assign a_ext = {1'b0, a};
  assign b_ext = {1'b0, b};
  // subtrahend of the borrow form: operand plus the complement of C
  assign subtr = b_ext + {{DATA_W{1'b0}}, ~c_in};

  always_comb begin
    wide   = a_ext;
    c_next = c_in;
    c_we   = 1'b0;
    case (op)
      OP_SUB: begin
        wide   = a_ext - b_ext;
        c_next = ~wide[DATA_W];
        c_we   = 1'b1;
      end
      OP_SBB: begin
        wide   = a_ext - subtr;
        c_next = ~wide[DATA_W];
        c_we   = 1'b1;
      end
      OP_ADD: begin
        wide   = a_ext + b_ext;
        c_next = wide[DATA_W];
        c_we   = 1'b1;
      end
      OP_SETC: begin
        c_next = 1'b1;
        c_we   = 1'b1;
      end
      OP_CLRC: begin
        c_next = 1'b0;
        c_we   = 1'b1;
      end
      default: ;
    endcase
  end

  assign res = wide[DATA_W-1:0];
endmodule

// File: rtl/acc_flag_tc.sv
module acc_flag_tc
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [IDX_W-1:0]  idx,
  input  logic              tc_in,
  output logic              tc_next,
  output logic              tc_we
);
  logic acc_zero, top_diff;

  assign acc_zero = (acc == '0);
  assign top_diff = acc[DATA_W-1] ^ acc[DATA_W-2];

  always_comb begin
    tc_next = tc_in;
    tc_we   = 1'b1;
    case (op)
      OP_TBIT:  tc_next = opnd[idx];
      OP_NORM:  tc_next = acc_zero | top_diff;
      OP_SETTC: tc_next = 1'b1;
      OP_CLRTC: tc_next = 1'b0;
      default:  tc_we   = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_flag_regs.sv
module acc_flag_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [DATA_W-1:0] res_next,
  input  logic              c_next,
  input  logic              c_we,
  input  logic              tc_next,
  input  logic              tc_we,
  output logic [DATA_W-1:0] res_q,
  output logic              c_q,
  output logic              tc_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      c_q    <= 1'b0;
      tc_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= vld;
      if (vld) begin
        res_q <= res_next;
        if (c_we)  c_q  <= c_next;
        if (tc_we) tc_q <= tc_next;
      end
    end
  end

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(c_q) && $stable(tc_q) && $stable(res_q) && !done_q));

  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!c_q && !tc_q && !done_q));

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
    vld |=> done_q);
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              tc_o,
  output logic              done_o
);
  logic [DATA_W-1:0] arith_res, res_next;
  logic              c_next, c_we, tc_next, tc_we;

  acc_flag_arith #(.DATA_W(DATA_W)) u_arith (
    .op     (op_i),
    .a      (acc_i),
    .b      (opnd_i),
    .c_in   (c_o),
    .res    (arith_res),
    .c_next (c_next),
    .c_we   (c_we)
  );

  acc_flag_tc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_tc (
    .op      (op_i),
    .acc     (acc_i),
    .opnd    (opnd_i),
    .idx     (bit_idx_i),
    .tc_in   (tc_o),
    .tc_next (tc_next),
    .tc_we   (tc_we)
  );

  assign res_next = op_is_arith(op_i) ? arith_res : acc_i;

  acc_flag_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .vld      (op_vld_i),
    .res_next (res_next),
    .c_next   (c_next),
    .c_we     (c_we),
    .tc_next  (tc_next),
    .tc_we    (tc_we),
    .res_q    (res_o),
    .c_q      (c_o),
    .tc_q     (tc_o),
    .done_q   (done_o)
  );

  assert_bit_test_R4: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && op_i == OP_TBIT) |=> (tc_o == $past(opnd_i[bit_idx_i])));

  assert_norm_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && op_i == OP_NORM && acc_i == '0) |=> tc_o);

  assert_force_c_R6: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && (op_i == OP_SETC || op_i == OP_CLRC)) |=> (c_o == ($past(op_i) == OP_SETC)));

  assert_force_tc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && (op_i == OP_SETTC || op_i == OP_CLRTC)) |=> (tc_o == ($past(op_i) == OP_SETTC)));

  assert_tc_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && (op_i == OP_SUB || op_i == OP_SBB || op_i == OP_ADD)) |=> $stable(tc_o));

  assert_c_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    (op_vld_i && (op_i == OP_TBIT || op_i == OP_NORM || op_i == OP_SETTC || op_i == OP_CLRTC))
      |=> $stable(c_o));
endmodule

// File: tb/acc_flag_unit_tb_top.sv
module acc_flag_unit_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_vld;
  logic [3:0]    op;
  logic [DW-1:0] acc, opnd;
  logic [4:0]    idx;
  logic [DW-1:0] res;
  logic          c, tc, done;

  typedef struct {
    logic [DW-1:0] res;
    logic          c;
    logic          tc;
    logic [3:0]    op;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  logic m_c   = 1'b0;
  logic m_tc  = 1'b0;
  logic [DW-1:0] m_res = '0;
  bit   finished = 0;

  always #5 clk = ~clk;

  acc_flag_unit dut_i (
    .clk(clk), .rst(rst), .op_vld_i(op_vld), .op_i(op), .acc_i(acc),
    .opnd_i(opnd), .bit_idx_i(idx), .res_o(res), .c_o(c), .tc_o(tc), .done_o(done)
  );

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4 R7";
      4'd4: return "R5 R7";
      4'd5, 4'd6, 4'd7, 4'd8: return "R6 R7";
      default: return "R7";
    endcase
  endfunction

  // reference model: computes expectations and advances model flags
  task automatic issue(input logic [3:0] o, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [4:0] ix);
    exp_t   e;
    longint d;
    @(negedge clk);
    op_vld = 1'b1; op = o; acc = a; opnd = b; idx = ix;
    e.res = a; e.c = m_c; e.tc = m_tc; e.op = o;
    case (o)
      4'd0: begin d = longint'(a) - longint'(b); e.res = d[DW-1:0]; e.c = (d >= 0); end
      4'd1: begin d = longint'(a) - longint'(b) - (m_c ? 0 : 1); e.res = d[DW-1:0]; e.c = (d >= 0); end
      4'd2: begin d = longint'(a) + longint'(b); e.res = d[DW-1:0]; e.c = d[DW]; end
      4'd3: e.tc = b[ix];
      4'd4: e.tc = (a == 0) ? 1'b1 : (a[31] ^ a[30]);
      4'd5: e.c = 1'b1;
      4'd6: e.c = 1'b0;
      4'd7: e.tc = 1'b1;
      4'd8: e.tc = 1'b0;
      default: ;
    endcase
    m_c = e.c; m_tc = e.tc; m_res = e.res;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_vld = 1'b0;
      acc = $urandom; opnd = $urandom; op = 4'($urandom); idx = 5'($urandom);
    end
  endtask

  task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, ex);
    end
  endtask

  // monitor: samples 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (!rst && !finished) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(done === 1'b1, "R10 done", {31'b0, done}, 1);
        chk(res === e.res && c === e.c && tc === e.tc, tag(e.op),
            {res[DW-3:0], c, tc}, {e.res[DW-3:0], e.c, e.tc});
        if (e.op <= 4'd2) chk(res === e.res, tag(e.op), res, e.res);
      end else begin
        chk(done === 1'b0 && c === m_c && tc === m_tc && res === m_res, "R8 idle",
            {res[DW-4:0], done, c, tc}, {m_res[DW-4:0], 1'b0, m_c, m_tc});
      end
    end
  end

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; op_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(c === 0 && tc === 0 && done === 0 && res === 0, "R9 reset",
        {res[DW-4:0], c, tc, done}, 0);
    rst = 1'b0;
    m_c = 0; m_tc = 0; m_res = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [DW-1:0] CORNER [5] = '{32'h0, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h1};

  initial begin
    rst = 1'b1; op_vld = 1'b0; op = '0; acc = '0; opnd = '0; idx = '0;
    do_reset();
    idle(3);
    // R1 R2 R3: corner operands, both incoming C values, equal operands
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        for (int k = 0; k < 2; k++) begin
          issue(k ? 4'd5 : 4'd6, '0, '0, '0);
          issue(4'd1, CORNER[i], CORNER[j], '0);
          issue(k ? 4'd5 : 4'd6, '0, '0, '0);
          issue(4'd0, CORNER[i], CORNER[j], '0);
          issue(4'd2, CORNER[i], CORNER[j], '0);
        end
      end
    end
    // R5: normalize corners
    issue(4'd4, 32'h0, '0, '0);
    issue(4'd4, 32'h40000000, '0, '0);
    issue(4'd4, 32'hC0000000, '0, '0);
    issue(4'd4, 32'h80000000, '0, '0);
    issue(4'd4, 32'h00000001, '0, '0);
    // R4: every bit index, single bit set and cleared
    for (int b = 0; b < 32; b++) begin
      issue(4'd3, '0, 32'h1 << b, 5'(b));
      issue(4'd3, '0, ~(32'h1 << b), 5'(b));
    end
    // R6 R7: forcing and unused codes
    issue(4'd7, 32'h1234, '0, '0);
    issue(4'd6, '0, '0, '0);
    issue(4'd8, '0, '0, '0);
    issue(4'd5, '0, '0, '0);
    for (int o = 9; o < 16; o++) issue(4'(o), 32'hABCD0000 + o, $urandom, '0);
    idle(4);
    // random mix with gaps (R8 during gaps)
    for (int n = 0; n < 3000; n++) begin
      issue(4'($urandom_range(0, 9)), $urandom, $urandom, 5'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    // R9 from a non-zero state
    issue(4'd5, '0, '0, '0);
    issue(4'd7, '0, '0, '0);
    issue(4'd2, 32'hFFFFFFFF, 32'h5, '0);
    idle(2);
    do_reset();
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule